// File: doc/BRIEF.md
# DMA Descriptor Completion Sequencer

This block decides how one endpoint DMA channel finishes the work described by a chain of buffer descriptors. A descriptor is handed in with a byte length, a flag that says whether a linked descriptor follows, and a direction. Each byte moved between the endpoint and memory is reported with a strobe. The block counts these bytes down against the length. When the last byte of the buffer is counted, it raises an end-of-transfer event.

How the descriptor closes depends on where the buffer ended. If it ended together with the packet, the descriptor completes normally. If it ended part-way through a packet and a linked descriptor exists, the block asks for that descriptor and stalls byte counting until it is loaded. If no linked descriptor exists, the outcome depends on direction. An outbound transfer (into memory) reports a data overrun and switches the channel off. An inbound transfer (toward the host) completes normally and is sent as a short packet. A zero-length inbound descriptor completes at once and emits a zero-length-packet marker.

Top module: `dd_done_seq`

## Requirements
- R1: After reset, `dd_status` is 0, `ch_en` is 1, and `chain_req`, `eot_pulse`, `eot_flag`, `short_pkt` and `zlp` are all 0.
- R2: A load is accepted only while `ch_en` is 1 and the block is idle or has `chain_req` high. A load of nonzero length sets `dd_status` to 1. Status codes are: 0 not serviced, 1 being serviced, 2 normal completion, 3 data overrun. While a descriptor runs, each `byte_stb` counts exactly one byte.
- R3: When the byte that reaches the buffer length carries `pkt_end`=1, the next cycle shows `eot_pulse` high for that single cycle and `dd_status`=2, and the block returns to idle.
- R4: `eot_flag` sets with every end-of-transfer pulse and stays set until `eot_clr` is 1. A set in the same cycle as a clear wins.
- R5: When the buffer length is reached without `pkt_end` and the next-valid flag is 1, the block shows `eot_pulse`, `dd_status`=2 and `chain_req`=1. Byte strobes are not counted while `chain_req` is high.
- R6: A load accepted while `chain_req` is high reloads the byte count with the new length in that cycle. The first strobe of the following cycle counts against the new descriptor.
- R7: With direction 0 (outbound), a buffer that fills without `pkt_end` and with next-valid 0 ends with `dd_status`=3 and `ch_en`=0.
- R8: While `ch_en` is 0, loads and byte strobes have no effect. `en_set` makes `ch_en` 1 on the next cycle.
- R9: With direction 1 (inbound), a buffer that fills without `pkt_end` and with next-valid 0 ends with `dd_status`=2 and a one-cycle `short_pkt` pulse.
- R10: A descriptor of length 0 completes in the cycle it is accepted, with `eot_pulse` and `dd_status`=2. If its direction is 1, `zlp` pulses at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dd_load | input | 1 | Present a descriptor |
| dd_len | input | LEN_W | Buffer length in bytes |
| dd_nxt_vld | input | 1 | A linked descriptor follows |
| dd_dir_in | input | 1 | 1 = inbound (to host), 0 = outbound (to memory) |
| byte_stb | input | 1 | One byte moved this cycle |
| pkt_end | input | 1 | This byte is the last of its packet |
| en_set | input | 1 | Re-enable the channel |
| eot_clr | input | 1 | Write-one-to-clear for `eot_flag` |
| chain_req | output | 1 | Waiting for the linked descriptor |
| dd_status | output | 3 | Descriptor status code |
| ch_en | output | 1 | Channel enable |
| eot_pulse | output | 1 | One-cycle end-of-transfer event |
| eot_flag | output | 1 | Sticky end-of-transfer flag |
| short_pkt | output | 1 | Inbound short packet marker |
| zlp | output | 1 | Zero-length packet marker |

## Verification
The bench targets a buffer that fills mid-packet in each of the three cases: linked descriptor present, outbound without one, and inbound without one. A design that swapped the direction rules would flag overrun on inbound data, or send a short packet where it should disable the channel. Bytes strobed while waiting for the linked descriptor, or while the channel is disabled, must leave the count untouched. Otherwise the end-of-transfer pulse arrives a cycle early or appears when it should not. Zero-length descriptors, both at first load and as a linked descriptor, check that completion happens in the accept cycle. The same-cycle set-and-clear of the sticky flag checks which of the two wins.

// File: rtl/dd_seq_pkg.sv
package dd_seq_pkg;

    typedef enum logic [2:0] {
        ST_NONE = 3'd0,
        ST_BUSY = 3'd1,
        ST_DONE = 3'd2,
        ST_OVR  = 3'd3
    } dd_stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_LINK = 2'd2
    } phase_e;

    typedef struct packed {
        dd_stat_e stat;
        logic     go_link;
        logic     kill_en;
        logic     short_pkt;
    } close_t;

    // Outcome of a buffer that fills before its packet ends.
    function automatic close_t mid_packet_close(input logic dir_in, input logic nxt_vld);
        close_t c;
        c = '{stat: ST_DONE, go_link: 1'b0, kill_en: 1'b0, short_pkt: 1'b0};
        if (nxt_vld) begin
            c.go_link = 1'b1;
        end else if (dir_in) begin
            c.short_pkt = 1'b1;
        end else begin
            c.stat    = ST_OVR;
            c.kill_en = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dd_byte_ctr.sv
module dd_byte_ctr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)       remain <= '0;
        else if (load) remain <= load_val;
        else if (dec)  remain <= remain - ONE;
    end

    assign last = (remain == ONE);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> remain != '0);

endmodule

// File: rtl/dd_close_dec.sv
module dd_close_dec
    import dd_seq_pkg::*;
(
    input  logic   dir_in,
    input  logic   nxt_vld,
    output close_t act
);
    always_comb act = mid_packet_close(dir_in, nxt_vld);
endmodule

// File: rtl/dd_done_seq.sv
module dd_done_seq
    import dd_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dd_load,
    input  logic [LEN_W-1:0] dd_len,
    input  logic             dd_nxt_vld,
    input  logic             dd_dir_in,
    input  logic             byte_stb,
    input  logic             pkt_end,
    input  logic             en_set,
    input  logic             eot_clr,
    output logic             chain_req,
    output logic [2:0]       dd_status,
    output logic             ch_en,
    output logic             eot_pulse,
    output logic             eot_flag,
    output logic             short_pkt,
    output logic             zlp
);
    phase_e   phase;
    dd_stat_e stat_q;
    logic     dir_q, nxt_q;
    logic     accept, zero_len, byte_ok, last, hit, eot_set;
    close_t   act;

    assign accept   = dd_load && ch_en && (phase != PH_RUN);
    assign zero_len = (dd_len == '0);
    assign byte_ok  = byte_stb && ch_en && (phase == PH_RUN);
    assign hit      = byte_ok && last;
    assign eot_set  = (accept && zero_len) || hit;

    dd_byte_ctr #(.LEN_W(LEN_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (dd_len),
        .dec      (byte_ok),
        .last     (last)
    );

    dd_close_dec i_dec (
        .dir_in  (dir_q),
        .nxt_vld (nxt_q),
        .act     (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            stat_q    <= ST_NONE;
            dir_q     <= 1'b0;
            nxt_q     <= 1'b0;
            ch_en     <= 1'b1;
            eot_pulse <= 1'b0;
            eot_flag  <= 1'b0;
            short_pkt <= 1'b0;
            zlp       <= 1'b0;
        end else begin
            eot_pulse <= eot_set;
            short_pkt <= 1'b0;
            zlp       <= 1'b0;
            if (en_set) ch_en <= 1'b1;
            if (eot_set)      eot_flag <= 1'b1;
            else if (eot_clr) eot_flag <= 1'b0;
            if (accept) begin
                dir_q <= dd_dir_in;
                nxt_q <= dd_nxt_vld;
                if (zero_len) begin
                    stat_q <= ST_DONE;
                    zlp    <= dd_dir_in;
                    phase  <= PH_IDLE;
                end else begin
                    stat_q <= ST_BUSY;
                    phase  <= PH_RUN;
                end
            end else if (hit) begin
                if (pkt_end) begin
                    stat_q <= ST_DONE;
                    phase  <= PH_IDLE;
                end else begin
                    stat_q    <= act.stat;
                    phase     <= act.go_link ? PH_LINK : PH_IDLE;
                    short_pkt <= act.short_pkt;
                    if (act.kill_en) ch_en <= 1'b0;
                end
            end
        end
    end

    assign chain_req = (phase == PH_LINK);
    assign dd_status = stat_q;

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eot_flag) |-> eot_pulse);
    // R7
    en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ch_en) |-> dd_status == 3'd3);
    // R9
    short_stat_chk: assert property (@(posedge clk) disable iff (rst)
        short_pkt |-> (dd_status == 3'd2) && eot_pulse && !chain_req);
    // R10
    zlp_stat_chk: assert property (@(posedge clk) disable iff (rst)
        zlp |-> (dd_status == 3'd2) && eot_pulse);
    // R5
    link_stat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chain_req) |-> eot_pulse && (dd_status == 3'd2));
    // R8
    dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ch_en |=> !eot_pulse && !zlp);
    // R3
    marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({short_pkt, zlp}));

endmodule

// File: tb/test_dd_done_seq.sv
module test_dd_done_seq;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dd_load = 0, dd_nxt_vld = 0, dd_dir_in = 0, byte_stb = 0;
    logic pkt_end = 0, en_set = 0, eot_clr = 0;
    logic [LEN_W-1:0] dd_len = '0;
    logic chain_req, ch_en, eot_pulse, eot_flag, short_pkt, zlp;
    logic [2:0] dd_status;

    always #10 clk = ~clk;

    dd_done_seq #(.LEN_W(LEN_W)) i_dd_done_seq (.*);

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference model state (phase: 0 idle, 1 running, 2 awaiting link)
    int m_ph, m_rem, m_stat;
    bit m_dir, m_nxt, m_en, m_eot, m_flag, m_short, m_zlp;

    function void m_reset();
        m_ph = 0; m_rem = 0; m_stat = 0; m_dir = 0; m_nxt = 0;
        m_en = 1; m_eot = 0; m_flag = 0; m_short = 0; m_zlp = 0;
    endfunction

    function void m_step(bit ld, int len, bit nv, bit din, bit b, bit pe, bit es, bit clr);
        bit was_en;
        was_en = m_en;
        m_eot = 0; m_short = 0; m_zlp = 0;
        if (es) m_en = 1;
        if (ld && was_en && m_ph != 1) begin
            m_dir = din; m_nxt = nv; m_rem = len;
            if (len == 0) begin
                m_eot = 1; m_stat = 2; m_zlp = din; m_ph = 0;
            end else begin
                m_stat = 1; m_ph = 1;
            end
        end else if (b && was_en && m_ph == 1) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
                m_eot = 1;
                if (pe) begin m_stat = 2; m_ph = 0; end
                else if (m_nxt) begin m_stat = 2; m_ph = 2; end
                else if (m_dir) begin m_stat = 2; m_short = 1; m_ph = 0; end
                else begin m_stat = 3; m_en = 0; m_ph = 0; end
            end
        end
        if (m_eot) m_flag = 1;
        else if (clr) m_flag = 0;
    endfunction

    function void cmp(string tag);
        logic [8:0] act, exp;
        act = {chain_req, dd_status, ch_en, eot_pulse, eot_flag, short_pkt, zlp};
        exp = {m_ph == 2, 3'(m_stat), m_en, m_eot, m_flag, m_short, m_zlp};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b (link,stat,en,eot,flag,short,zlp)",
                     tag, $time, act, exp);
        end
    endfunction

    task automatic step(string tag, bit ld = 0, int len = 0, bit nv = 0, bit din = 0,
                        bit b = 0, bit pe = 0, bit es = 0, bit clr = 0);
        dd_load = ld; dd_len = LEN_W'(len); dd_nxt_vld = nv; dd_dir_in = din;
        byte_stb = b; pkt_end = pe; en_set = es; eot_clr = clr;
        m_step(ld, len, nv, din, b, pe, es, clr);
        @(posedge clk);
        @(negedge clk);
        cmp(tag);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp("R1");
        step("R1");

        // R2 R3: outbound, buffer and packet end together
        step("R2", .ld(1), .len(3));
        step("R2", .b(1));
        step("R2");
        step("R2", .b(1));
        step("R3", .b(1), .pe(1));
        step("R3");
        // R4: clear, then set and clear together
        step("R4", .clr(1));
        step("R4", .ld(1), .len(0), .clr(1));
        step("R4");
        step("R4", .clr(1));

        // R5 R6: mid-packet with link
        step("R5", .ld(1), .len(2), .nv(1));
        step("R5", .b(1));
        step("R5", .b(1));
        step("R5", .b(1));
        step("R5", .b(1), .ld(0));
        step("R6", .ld(1), .len(3));
        step("R6", .b(1));
        step("R6", .b(1));
        step("R6", .b(1), .pe(1));

        // R7 R8: outbound overrun, then disabled channel
        step("R7", .ld(1), .len(2));
        step("R7", .b(1));
        step("R7", .b(1));
        step("R8", .ld(1), .len(1));
        step("R8", .b(1));
        step("R8", .ld(1), .len(0), .din(1));
        step("R8", .es(1));
        step("R8", .ld(1), .len(1));
        step("R8", .b(1), .pe(1));

        // R9: inbound short packet
        step("R9", .ld(1), .len(2), .din(1));
        step("R9", .b(1));
        step("R9", .b(1));
        step("R9");

        // R10: zero-length linked inbound, and zero-length at first load
        step("R10", .ld(1), .len(1), .nv(1), .din(1));
        step("R10", .b(1));
        step("R10", .ld(1), .len(0), .din(1));
        step("R10");
        step("R10", .ld(1), .len(0), .din(1));
        step("R10", .ld(1), .len(0), .din(0));

        // Mixed traffic against the model (R2 R5 R6 R7 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            step("R2",
                 .ld($urandom_range(0, 3) == 0), .len($urandom_range(0, 4)),
                 .nv($urandom_range(0, 1) == 1), .din($urandom_range(0, 1) == 1),
                 .b($urandom_range(0, 2) != 0), .pe($urandom_range(0, 3) == 0),
                 .es($urandom_range(0, 7) == 0), .clr($urandom_range(0, 3) == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule